// File: doc/BRIEF.md
# Display pixel clock generator

The block derives a display pixel clock from one of two source clocks, each represented by a qualifier that marks the reference-clock cycles on which that source ticks. A fractional pre-divider stretches the selected source by an average ratio of an integer plus a numerator over a denominator. A post-divider then either passes each pre-divided period straight through or groups N+1 of them into one pixel clock period.

Software-visible behaviour comes from one packed configuration word. It holds the post-division count, a bypass bit, the idle level, the first-half level, the integer and fractional divider values, and a two-bit source select. A run input starts and stops the clock. The block also gives a one-cycle strobe at the start of every pixel clock period.

The configuration is sampled only when a period starts or while the clock is stopped. Rewriting the word therefore never shortens or splits a period that is already under way.

Top module: `pixclk_gen`

## Requirements
- R1: After reset `pix_clk` and `period_stb` are 0. While `run` is 0, `pix_clk` shows the idle bit `cfg[7]` (1 means high) from the next cycle on, and no strobe is produced.
- R2: With bypass `cfg[6]` = 0, a pixel period lasts D*(N+1) source ticks, where N = `cfg[5:0]` and D is the pre-division length. For N+1 >= 2 the first half lasts ceil((N+1)/2)*D ticks, so an odd ratio gives a longer first half.
- R3: With bypass `cfg[6]` = 1, N has no effect. A pixel period equals one pre-divided period of L ticks, and its first half lasts ceil(L/2) ticks.
- R4: The phase bit `cfg[8]` gives the level of the first half of each period, and the second half takes the opposite level.
- R5: The integer divider `cfg[16:9]` gives D. A value of 0 acts as 1.
- R6: Let b = `cfg[22:17]` and a = `cfg[28:23]`. With 0 < b < a, an extra tick is added to some pre-divided periods, so that any a consecutive pre-divided periods after the first one after start total a*D + b ticks. With b = 0, a = 0 or b >= a, every pre-divided period lasts exactly D ticks.
- R7: The select field `cfg[30:29]` chooses the source: code 1 uses `src_a_en` and code 2 uses `src_b_en`. With code 0 or 3 the block stays at its idle level and produces no strobe, even while `run` is 1.
- R8: The divider chain advances only on reference cycles where the selected qualifier is 1. Outputs hold on all other cycles.
- R9: A configuration change takes effect only at the next period boundary. The period under way keeps its length.
- R10: `period_stb` is 1 for exactly one cycle, namely the first cycle of each period, and in that cycle `pix_clk` already shows the first-half level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_en | input | 1 | Tick qualifier of source 1 |
| src_b_en | input | 1 | Tick qualifier of source 2 |
| cfg | input | 31 | Packed configuration word |
| run | input | 1 | 1 runs the clock, 0 parks it at the idle level |
| pix_clk | output | 1 | Pixel clock level |
| period_stb | output | 1 | One-cycle strobe at each period start |

## Verification
All outputs come from registers. Each result therefore appears in the cycle after the reference edge that causes it.

A start from idle happens on the first qualified tick with `run` high. From that edge, the strobe and the first-half level are visible in the following cycle. The half flip and the next strobe come exactly after the number of ticks given by R2 and R3.

The bench drives inputs and samples outputs on the falling edge. It counts samples from one strobe to the next, so the period length and the first-half length are read off directly in reference cycles. When `run` falls or a mid-period change is made, the check is placed in the first sample after the edge at which the change is captured.

// File: rtl/pixclk_gen.sv
module pixclk_gen #(
  parameter int NW = 6,
  parameter int DW = 8,
  parameter int FW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    src_a_en,
  input  logic                    src_b_en,
  input  logic [NW+DW+2*FW+4:0]   cfg,
  input  logic                    run,
  output logic                    pix_clk,
  output logic                    period_stb
);
  localparam int BYP    = NW;
  localparam int IDLE   = NW + 1;
  localparam int PH     = NW + 2;
  localparam int DIV_LO = NW + 3;
  localparam int B_LO   = DIV_LO + DW;
  localparam int A_LO   = B_LO + FW;
  localparam int SEL_LO = A_LO + FW;
  localparam int CW     = SEL_LO + 2;

  logic [CW-1:0] sh;
  logic          running;
  logic [DW-1:0] pc;
  logic [NW-1:0] pcnt;
  logic [FW-1:0] acc;
  logic          extra;

  function automatic logic src_ok(input logic [1:0] s, input logic ea, input logic eb);
    return (s == 2'd1 && ea) || (s == 2'd2 && eb);
  endfunction

  wire [1:0]  sel_live    = cfg[SEL_LO +: 2];
  wire        sel_live_ok = (sel_live == 2'd1) || (sel_live == 2'd2);
  wire        tick_live   = src_ok(sel_live, src_a_en, src_b_en);
  wire        tick        = src_ok(sh[SEL_LO +: 2], src_a_en, src_b_en);

  wire [DW-1:0] div_raw = sh[DIV_LO +: DW];
  wire [DW:0]   div     = (div_raw == '0) ? (DW+1)'(1) : {1'b0, div_raw};
  wire [FW-1:0] fb      = sh[B_LO +: FW];
  wire [FW-1:0] fa      = sh[A_LO +: FW];
  wire          frac_on = (fa != '0) && (fb != '0) && (fb < fa);
  wire [DW:0]   len     = div + {{DW{1'b0}}, extra};
  wire [NW:0]   ratio   = sh[BYP] ? (NW+1)'(1) : {1'b0, sh[NW-1:0]} + (NW+1)'(1);

  wire          pre_end  = tick && ({1'b0, pc} == len - (DW+1)'(1));
  wire          pix_end  = pre_end && ({1'b0, pcnt} == ratio - (NW+1)'(1));
  wire [DW:0]   half_tk  = (len >> 1) + {{DW{1'b0}}, len[0]};
  wire [NW:0]   half_pre = (ratio >> 1) + {{NW{1'b0}}, ratio[0]};
  wire          flip     = (ratio == (NW+1)'(1))
                         ? (tick && !pre_end && ({1'b0, pc} + (DW+1)'(1) == half_tk))
                         : (pre_end && ({1'b0, pcnt} + (NW+1)'(1) == half_pre));
  wire [FW:0]   sum      = {1'b0, acc} + {1'b0, fb};
  wire          wrap     = frac_on && (sum >= {1'b0, fa});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      pix_clk    <= 1'b0;
      period_stb <= 1'b0;
      sh         <= '0;
      pc         <= '0;
      pcnt       <= '0;
      acc        <= '0;
      extra      <= 1'b0;
    end else begin
      period_stb <= 1'b0;
      if (!run) begin
        running <= 1'b0;
        pix_clk <= cfg[IDLE];
        sh      <= cfg;
      end else if (!running) begin
        sh    <= cfg;
        pc    <= '0;
        pcnt  <= '0;
        acc   <= '0;
        extra <= 1'b0;
        if (tick_live) begin
          running    <= 1'b1;
          pix_clk    <= cfg[PH];
          period_stb <= 1'b1;
        end else begin
          pix_clk <= cfg[IDLE];
        end
      end else if (tick) begin
        if (pre_end) begin
          pc    <= '0;
          pcnt  <= pcnt + NW'(1);
          extra <= wrap;
          if (wrap)         acc <= FW'(sum - {1'b0, fa});
          else if (frac_on) acc <= FW'(sum);
          else              acc <= '0;
        end else begin
          pc <= pc + DW'(1);
        end
        if (pix_end) begin
          sh   <= cfg;
          pcnt <= '0;
          if (sel_live_ok) begin
            pix_clk    <= cfg[PH];
            period_stb <= 1'b1;
          end else begin
            running <= 1'b0;
            pix_clk <= cfg[IDLE];
          end
        end else if (flip) begin
          pix_clk <= ~sh[PH];
        end
      end
    end
  end

  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pix_clk == $past(cfg[IDLE])) && !period_stb);

  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && running && !tick) |=> ($stable(pix_clk) && !period_stb));

  a_r7_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (sh[SEL_LO +: 2] == 2'd1 || sh[SEL_LO +: 2] == 2'd2));

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && running && !pix_end) |=> $stable(sh));

  a_r10_strobe_level: assert property (@(posedge clk) disable iff (!rst_n)
    period_stb |-> (running && pix_clk == sh[PH]));
endmodule

// File: tb/pixclk_gen_test.sv
module pixclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_a = 1'b0, en_b = 1'b0, gate_mode = 1'b0, tog = 1'b0;
  logic [30:0] cfg = '0;
  logic        run = 1'b0;
  logic        pix_clk, period_stb;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  wire src_a_en = gate_mode ? tog : en_a;

  always #5 clk = ~clk;

  pixclk_gen uut (.clk(clk), .rst_n(rst_n), .src_a_en(src_a_en), .src_b_en(en_b),
                  .cfg(cfg), .run(run), .pix_clk(pix_clk), .period_stb(period_stb));

  always @(negedge clk) tog <= ~tog;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [30:0] mk(input int sel, input int a, input int b, input int dv,
                                     input bit ph, input bit idl, input bit byp, input int n);
    return {sel[1:0], a[5:0], b[5:0], dv[7:0], ph, idl, byp, n[5:0]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_stb(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (period_stb) begin ok = 1'b1; break; end
    end
  endtask

  // Called at a negedge where period_stb is 1; returns at the next such negedge.
  task automatic measure(input bit ph, output int per, output int fc);
    per = 0; fc = 0;
    do begin
      per++;
      if (pix_clk == ph) fc++;
      @(negedge clk);
    end while (!period_stb && per < 3000);
  endtask

  task automatic start(input logic [30:0] c);
    @(negedge clk);
    run = 1'b0; cfg = c;
    repeat (3) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic run_case(input string tag, input logic [30:0] c, input bit ph,
                          input int exp_per, input int exp_fc);
    bit ok; int per, fc;
    start(c);
    wait_stb(ok);
    chk({tag, " started"}, ok, 1);
    measure(ph, per, fc);
    chk({tag, " level at strobe R10"}, pix_clk, ph);
    measure(ph, per, fc);
    chk({tag, " period"}, per, exp_per);
    chk({tag, " first half"}, fc, exp_fc);
  endtask

  task automatic t_reset;
    chk("R1 reset pix_clk", pix_clk, 0);
    chk("R1 reset strobe", period_stb, 0);
    @(negedge clk); cfg = mk(1, 0, 0, 2, 0, 1, 0, 0);
    @(negedge clk);
    chk("R1 idle high", pix_clk, 1);
    chk("R1 no strobe idle", period_stb, 0);
  endtask

  task automatic t_post;
    run_case("R2 even N=3 D=2", mk(1, 0, 0, 2, 1, 0, 0, 3), 1'b1, 8, 4);
    run_case("R2 odd N=2 D=3", mk(1, 0, 0, 3, 1, 0, 0, 2), 1'b1, 9, 6);
  endtask

  task automatic t_bypass;
    run_case("R3 R4 bypass D=5 phase0", mk(1, 0, 0, 5, 0, 1, 1, 5), 1'b0, 5, 3);
  endtask

  task automatic t_div0;
    run_case("R5 D=0 N=1", mk(1, 0, 0, 0, 1, 0, 0, 1), 1'b1, 2, 1);
  endtask

  task automatic t_frac(input int a, input int b, input int exp_sum, input string tag);
    bit ok; int per, fc, tot;
    start(mk(1, a, b, 3, 1, 0, 1, 0));
    wait_stb(ok);
    measure(1'b1, per, fc);
    tot = 0;
    for (int k = 0; k < 4; k++) begin
      measure(1'b1, per, fc);
      tot += per;
    end
    chk(tag, tot, exp_sum);
  endtask

  task automatic t_source;
    bit ok;
    en_a = 1'b0; en_b = 1'b1;
    run_case("R7 code2 src_b", mk(2, 0, 0, 2, 1, 0, 0, 1), 1'b1, 4, 2);
    start(mk(1, 0, 0, 2, 1, 1, 0, 1));
    wait_stb(ok);
    chk("R7 code1 with src_a off no strobe", ok, 0);
    chk("R7 code1 src_a off idle level", pix_clk, 1);
    en_a = 1'b1;
    start(mk(0, 0, 0, 2, 0, 1, 0, 1));
    wait_stb(ok);
    chk("R7 code0 no strobe", ok, 0);
    chk("R7 code0 idle level", pix_clk, 1);
    start(mk(3, 0, 0, 2, 1, 0, 0, 1));
    wait_stb(ok);
    chk("R7 code3 no strobe", ok, 0);
    chk("R7 code3 idle level", pix_clk, 0);
    en_b = 1'b0;
  endtask

  task automatic t_gate;
    int per, fc; bit ok;
    gate_mode = 1'b1;
    start(mk(1, 0, 0, 2, 1, 0, 0, 1));
    wait_stb(ok);
    measure(1'b1, per, fc);
    measure(1'b1, per, fc);
    chk("R8 half-rate qualifier period", per, 8);
    chk("R8 half-rate qualifier first half", fc, 4);
    gate_mode = 1'b0;
  endtask

  task automatic t_change;
    int per, fc; bit ok;
    start(mk(1, 0, 0, 2, 1, 0, 0, 3));
    wait_stb(ok);
    measure(1'b1, per, fc);
    per = 0;
    do begin
      per++;
      if (per == 3) cfg = mk(1, 0, 0, 1, 1, 0, 0, 1);
      @(negedge clk);
    end while (!period_stb && per < 3000);
    chk("R9 period under way kept", per, 8);
    measure(1'b1, per, fc);
    chk("R9 new period used", per, 2);
  endtask

  task automatic t_stop;
    bit ok; int per, fc;
    start(mk(1, 0, 0, 4, 1, 0, 0, 3));
    wait_stb(ok);
    repeat (2) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R1 run low idle level", pix_clk, 0);
    wait_stb(ok);
    chk("R1 no strobe after stop", ok, 0);
    start(mk(1, 0, 0, 1, 1, 0, 0, 2));
    wait_stb(ok);
    measure(1'b1, per, fc);
    chk("R10 strobe one cycle (next period has no early strobe)", per, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    en_a = 1'b1;
    t_reset();
    t_post();
    t_bypass();
    t_div0();
    t_frac(4, 1, 13, "R6 fraction 1/4 over 4 periods");
    t_frac(0, 2, 12, "R6 fraction off a=0");
    t_frac(4, 5, 12, "R6 fraction off b>=a");
    t_source();
    t_gate();
    t_change();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule